// File: doc/BRIEF.md
# Wrapping Event Timer with Compare Reset

A free-running timestamp counter with a small register port and one level interrupt line. Each enabled tick adds a programmable step to a 32-bit count. The count wraps modulo 2^32 and does not saturate. The tick comes from one of two count-enable inputs, chosen by a control bit, so the same counter can follow either of two clock rates that the surrounding logic has already reduced to enables.

A compare register can end each period early. When the count equals the compare value at a tick and reset-on-match is enabled, the count returns to zero, which gives a programmable period. Two sticky flags record events: one for a wrap past all-ones and one for a compare match. Software clears a flag by writing one to its bit. The interrupt line is high while any flag is set whose enable bit is also set.

Preloading all-ones and then starting the timer makes the first tick wrap. That tick sets the wrap flag and counting continues from zero. If the flag is cleared while the count still holds all-ones, the next tick sets it again.

Top module: `evt_timer`

## Requirements
- R1: While reset is asserted and after its release, the count, the control register, the compare register, the interrupt enables and both flags are zero, and irq_o is low.
- R2: With CTRL bit 0 (run) set, every cycle in which the selected tick input is high adds CTRL bits 7:4 (step) to the count. With run clear, the count holds.
- R3: CTRL bit 8 selects the tick source: 0 selects tick_a_i and 1 selects tick_b_i. The other input has no effect on the count.
- R4: The count wraps modulo 2^32 and never saturates. A tick whose sum carries out of bit 31 sets STAT bit 0 (wrap flag).
- R5: With CTRL bit 9 set, a tick that finds the count equal to CMP0 loads zero instead of adding the step. That tick does not set the wrap flag.
- R6: With CTRL bit 10 set, a tick that finds the count equal to CMP0 sets STAT bit 1 (match flag). With bit 10 clear, a match leaves the flag unchanged.
- R7: Writing STAT clears each flag whose bit in the written data is one. Bits written as zero leave their flag unchanged. A flag set by hardware in the same cycle as its clear stays set.
- R8: A write to COUNT loads the written data. If a tick arrives in the same cycle, that tick is discarded and raises no flag.
- R9: After all-ones is written to COUNT while run is clear, the first tick after run is set moves the count to zero and sets the wrap flag.
- R10: Clearing the wrap flag while the count holds all-ones does not prevent the next tick from setting the flag again.
- R11: irq_o is high exactly while some flag is set whose bit in IEN (bit 0 wrap, bit 1 match) is set. It stays high until that flag is cleared or its enable is cleared.
- R12: Register addresses are CTRL=0, STAT=1, COUNT=2, CMP0=3, IEN=4. reg_rdata_o shows the addressed register combinationally, with undefined bits and unmapped addresses reading zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wen_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| tick_a_i | input | 1 | Count enable, source A |
| tick_b_i | input | 1 | Count enable, source B |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench focuses on the edges of the all-ones value. It preloads all-ones and then starts the timer, and it clears the wrap flag while the count is still all-ones. A design that detects the wrap from the count reading zero, or that lets the clear win, misses the re-set that follows. It lands a flag clear and a hardware set in the same cycle, and a count write on top of a tick; a wrong priority there loses an event or corrupts the loaded value. It puts the compare value at all-ones with reset-on-match enabled, where a design that also flags the carry raises a wrap event that never happened. It also checks that the unselected tick input has no effect on the count.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned STEP_W  = 4;
  localparam int unsigned NUM_EVT = 2;
  localparam int unsigned EVT_WRAP = 0;
  localparam int unsigned EVT_CMP  = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_COUNT = 3'd2,
    A_CMP0  = 3'd3,
    A_IEN   = 3'd4
  } reg_addr_e;

  // control bit positions
  localparam int unsigned C_RUN  = 0;
  localparam int unsigned C_STEP = 4;
  localparam int unsigned C_SRC  = 8;
  localparam int unsigned C_CRST = 9;
  localparam int unsigned C_CEVT = 10;

  typedef struct packed {
    logic              cmp_evt;
    logic              cmp_rst;
    logic              src_b;
    logic [STEP_W-1:0] step;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wen_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [NUM_EVT-1:0] flags_i,
  output ctrl_t              ctrl_o,
  output logic [CNT_W-1:0]   cmp_o,
  output logic [NUM_EVT-1:0] ien_o,
  output logic               cnt_we_o,
  output logic [NUM_EVT-1:0] clr_o,
  output logic [CNT_W-1:0]   rdata_o
);
  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   cmp_q;
  logic [NUM_EVT-1:0] ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      ien_q  <= '0;
    end else if (wen_i) begin
      unique case (addr_i)
        A_CTRL: begin
          ctrl_q.run     <= wdata_i[C_RUN];
          ctrl_q.step    <= wdata_i[C_STEP +: STEP_W];
          ctrl_q.src_b   <= wdata_i[C_SRC];
          ctrl_q.cmp_rst <= wdata_i[C_CRST];
          ctrl_q.cmp_evt <= wdata_i[C_CEVT];
        end
        A_CMP0: cmp_q <= wdata_i;
        A_IEN:  ien_q <= wdata_i[NUM_EVT-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cnt_we_o = wen_i && (addr_i == A_COUNT);
    clr_o    = (wen_i && (addr_i == A_STAT)) ? wdata_i[NUM_EVT-1:0] : '0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[C_RUN]             = ctrl_q.run;
        rdata_o[C_STEP +: STEP_W]  = ctrl_q.step;
        rdata_o[C_SRC]             = ctrl_q.src_b;
        rdata_o[C_CRST]            = ctrl_q.cmp_rst;
        rdata_o[C_CEVT]            = ctrl_q.cmp_evt;
      end
      A_STAT:  rdata_o[NUM_EVT-1:0] = flags_i;
      A_COUNT: rdata_o = cnt_i;
      A_CMP0:  rdata_o = cmp_q;
      A_IEN:   rdata_o[NUM_EVT-1:0] = ien_q;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign cmp_o  = cmp_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic              cmp_rst_i,
  input  logic              cmp_evt_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o,
  output logic              match_o
);
  localparam int unsigned PAD_W = CNT_W + 1 - STEP_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;
  logic             hit, adv, rst_hit;

  always_comb begin
    sum     = {1'b0, cnt_q} + {{PAD_W{1'b0}}, step_i};
    hit     = (cnt_q == cmp_i);
    adv     = tick_i && !wr_en_i;   // write wins, tick dropped
    rst_hit = adv && cmp_rst_i && hit;
    if (wr_en_i)      cnt_d = wr_data_i;
    else if (rst_hit) cnt_d = '0;
    else if (adv)     cnt_d = sum[CNT_W-1:0];
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign wrap_o  = adv && !rst_hit && sum[CNT_W];
  assign match_o = adv && cmp_evt_i && hit;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/evt_timer_flags.sv
module evt_timer_flags
  import evt_timer_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  input  logic [NUM_EVT-1:0] ien_i,
  output logic [NUM_EVT-1:0] flags_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] flag_q;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & ien_i);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wen_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  input  logic              tick_a_i,
  input  logic              tick_b_i,
  output logic              irq_o
);
  ctrl_t              ctrl;
  logic [CNT_W-1:0]   cmp0, cnt;
  logic [NUM_EVT-1:0] ien, flags, clr, evt_set;
  logic               cnt_we, tick_sel, wrap_evt, match_evt;

  evt_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wen_i    (reg_wen_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .cnt_i    (cnt),
    .flags_i  (flags),
    .ctrl_o   (ctrl),
    .cmp_o    (cmp0),
    .ien_o    (ien),
    .cnt_we_o (cnt_we),
    .clr_o    (clr),
    .rdata_o  (reg_rdata_o)
  );

  assign tick_sel = ctrl.run && (ctrl.src_b ? tick_b_i : tick_a_i);

  evt_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_sel),
    .step_i    (ctrl.step),
    .cmp_i     (cmp0),
    .cmp_rst_i (ctrl.cmp_rst),
    .cmp_evt_i (ctrl.cmp_evt),
    .wr_en_i   (cnt_we),
    .wr_data_i (reg_wdata_i),
    .cnt_o     (cnt),
    .wrap_o    (wrap_evt),
    .match_o   (match_evt)
  );

  always_comb begin
    evt_set           = '0;
    evt_set[EVT_WRAP] = wrap_evt;
    evt_set[EVT_CMP]  = match_evt;
  end

  evt_timer_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_set),
    .clr_i   (clr),
    .ien_i   (ien),
    .flags_o (flags),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_wen_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [CNT_W-1:0]   reg_wdata_i,
  input logic               irq_o,
  input logic               tick_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [CNT_W-1:0]   cmp_i,
  input logic               cmp_rst_i,
  input logic [STEP_W-1:0]  step_i,
  input logic [NUM_EVT-1:0] flags_i
);
  logic cnt_wr, stat_wr, ien_wr;
  assign cnt_wr  = reg_wen_i && (reg_addr_i == A_COUNT);
  assign stat_wr = reg_wen_i && (reg_addr_i == A_STAT);
  assign ien_wr  = reg_wen_i && (reg_addr_i == A_IEN);

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (cnt_i == '0 && flags_i == '0 && !irq_o));

  a_r2_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr) |=> $stable(cnt_i));

  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cnt_i == $past(reg_wdata_i)));

  a_r4_wrap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr && cnt_i == '1 && step_i != '0 &&
     !(cmp_rst_i && cmp_i == cnt_i)) |=> flags_i[EVT_WRAP]);

  a_r5_cmp_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr && cmp_rst_i && cnt_i == cmp_i) |=> (cnt_i == '0));

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i[EVT_WRAP] && !(stat_wr && reg_wdata_i[EVT_WRAP])) |=> flags_i[EVT_WRAP]);

  a_r11_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_wr && !ien_wr) |=> irq_o);
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wen_i   (reg_wen_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .tick_i      (tick_sel),
  .cnt_i       (cnt),
  .cmp_i       (cmp0),
  .cmp_rst_i   (ctrl.cmp_rst),
  .step_i      (ctrl.step),
  .flags_i     (flags)
);

// File: tb/evt_timer_tb_top.sv
`timescale 1ns/1ps
module evt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wen = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick_a = 1'b0, tick_b = 1'b0;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, CNT = 3'd2, CMP = 3'd3, IEN = 3'd4;

  always #2.5 clk = ~clk;

  evt_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wen_i(wen), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tick_a_i(tick_a),
    .tick_b_i(tick_b), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0;
  endtask

  // write and tick source A in the same cycle
  task automatic wr_tick(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1; tick_a = 1'b1;
    @(negedge clk); wen = 1'b0; tick_a = 1'b0;
  endtask

  task automatic ticks(bit use_b, int n);
    @(negedge clk);
    if (use_b) tick_b = 1'b1; else tick_a = 1'b1;
    repeat (n) @(negedge clk);
    tick_a = 1'b0; tick_b = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic chk_reg(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    chk_reg("R1 count", CNT, 32'h0);
    chk_reg("R1 ctrl", CTRL, 32'h0);
    chk_reg("R1 stat", STAT, 32'h0);
    chk_reg("R1 ien", IEN, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_count();
    wr(CTRL, 32'h11);
    ticks(1'b1, 5);
    chk_reg("R3 unselected b ignored", CNT, 32'd0);
    ticks(1'b0, 7);
    chk_reg("R2 step 1", CNT, 32'd7);
    wr(CTRL, 32'h31);
    ticks(1'b0, 4);
    chk_reg("R2 step 3", CNT, 32'd19);
    wr(CTRL, 32'h30);
    ticks(1'b0, 5);
    chk_reg("R2 run clear holds", CNT, 32'd19);
  endtask

  task automatic t_source();
    wr(CTRL, 32'h111);
    ticks(1'b1, 4);
    chk_reg("R3 source b", CNT, 32'd23);
    ticks(1'b0, 3);
    chk_reg("R3 unselected a ignored", CNT, 32'd23);
    chk_reg("R12 ctrl readback", CTRL, 32'h111);
    chk_reg("R12 unmapped", 3'd7, 32'h0);
  endtask

  task automatic t_wrap();
    wr(CTRL, 32'h10);
    wr(CNT, 32'hFFFF_FFFE);
    wr(CTRL, 32'h11);
    ticks(1'b0, 3);
    chk_reg("R4 wrap count", CNT, 32'd1);
    chk_reg("R4 wrap flag", STAT, 32'h1);
    wr(STAT, 32'h1);
    chk_reg("R7 clear", STAT, 32'h0);
    wr(CNT, 32'hFFFF_FFFD);
    wr(CTRL, 32'h51);
    ticks(1'b0, 1);
    chk_reg("R4 wrap step 5", CNT, 32'd2);
    chk_reg("R4 carry flag", STAT, 32'h1);
    wr(STAT, 32'h1);
  endtask

  task automatic t_preload();
    wr(CTRL, 32'h10);
    wr(CNT, 32'hFFFF_FFFF);
    wr(STAT, 32'h1);
    chk_reg("R9 no flag while stopped", STAT, 32'h0);
    wr(CTRL, 32'h11);
    ticks(1'b0, 1);
    chk_reg("R9 first tick count", CNT, 32'd0);
    chk_reg("R9 first tick flag", STAT, 32'h1);
  endtask

  task automatic t_reclear();
    wr(STAT, 32'h1);
    wr(CNT, 32'hFFFF_FFFF);
    wr(STAT, 32'h1);
    chk_reg("R10 cleared", STAT, 32'h0);
    ticks(1'b0, 1);
    chk_reg("R10 re-set", STAT, 32'h1);
    wr(STAT, 32'h0);
    chk_reg("R7 zero write no effect", STAT, 32'h1);
    wr(CNT, 32'hFFFF_FFFF);
    wr(STAT, 32'h1);
    wr_tick(STAT, 32'h1);
    chk_reg("R7 set wins over clear", STAT, 32'h1);
    chk_reg("R7 count after", CNT, 32'd0);
    wr(STAT, 32'h1);
  endtask

  task automatic t_prio();
    wr(CNT, 32'd10);
    wr_tick(CNT, 32'd100);
    chk_reg("R8 write beats tick", CNT, 32'd100);
    wr(CNT, 32'hFFFF_FFFF);
    wr_tick(CNT, 32'd5);
    chk_reg("R8 tick discarded", CNT, 32'd5);
    chk_reg("R8 no wrap flag", STAT, 32'h0);
  endtask

  task automatic t_compare();
    wr(CMP, 32'd4);
    wr(CNT, 32'd0);
    wr(CTRL, 32'h611);
    ticks(1'b0, 5);
    chk_reg("R5 period reset", CNT, 32'd0);
    chk_reg("R6 match flag", STAT, 32'h2);
    ticks(1'b0, 3);
    chk_reg("R5 next period", CNT, 32'd3);
    wr(STAT, 32'h3);
    wr(CMP, 32'hFFFF_FFFF);
    wr(CNT, 32'hFFFF_FFFE);
    ticks(1'b0, 2);
    chk_reg("R5 reset at all-ones", CNT, 32'd0);
    chk_reg("R5 no wrap on reset", STAT, 32'h2);
    wr(STAT, 32'h3);
    wr(CTRL, 32'h211);
    wr(CMP, 32'd2);
    wr(CNT, 32'd0);
    ticks(1'b0, 3);
    chk_reg("R6 disabled count", CNT, 32'd0);
    chk_reg("R6 disabled no flag", STAT, 32'h0);
  endtask

  task automatic t_irq();
    wr(CTRL, 32'h411);
    wr(CMP, 32'hFFFF_FFFF);
    wr(CNT, 32'hFFFF_FFFF);
    ticks(1'b0, 1);
    chk_reg("R6 match and wrap", STAT, 32'h3);
    chk("R11 masked", {31'b0, irq}, 32'h0);
    wr(IEN, 32'h2);
    @(negedge clk);
    chk("R11 enabled", {31'b0, irq}, 32'h1);
    repeat (5) @(negedge clk);
    chk("R11 level held", {31'b0, irq}, 32'h1);
    wr(STAT, 32'h1);
    chk("R11 other flag clear", {31'b0, irq}, 32'h1);
    wr(STAT, 32'h2);
    chk("R11 dropped", {31'b0, irq}, 32'h0);
    wr(IEN, 32'h1);
    chk("R11 no pending", {31'b0, irq}, 32'h0);
    chk_reg("R12 ien readback", IEN, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_source();
    t_wrap();
    t_preload();
    t_reclear();
    t_prio();
    t_compare();
    t_irq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule